// File: doc/BRIEF.md
# Programmable Multi-Mode Down-Counter Channel

One channel of a programmable interval timer. A 16-bit down counter advances on a counter-clock enable, is qualified or triggered by a gate input, and drives a single waveform output. All logic sits in one system-clock domain. The counter clock and the gate are sampled as enables, and a gate rising edge is a high gate on a tick whose previous tick saw the gate low.

A host write strobe loads a binary initial count and a two-bit mode at the same time. The same core then produces one of four waveforms: a level that rises at terminal count and holds until the next load, a retriggerable one-shot, a divide-by-N rate pulse, or a square wave. For odd counts the square wave is asymmetric and is formed by counting down in steps of two. The live count can be read at any time.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 1, `count_rd` is 0 and `load_err` is 0, and ticks have no effect until a load.
- R2: A write with `wr_en`=1 loads the count at the next clock edge, and a value of 0 stands for 65,536. The count shows on `count_rd`, where 65,536 reads as 0. A write takes priority over a counter tick in the same cycle, so that tick is dropped.
- R3: The mode encoding of `wr_mode` is 0 = level on terminal count, 1 = one-shot, 2 = rate generator and 3 = square wave. A mode-3 write of value 1 is rejected: it sets `load_err` to 1 and leaves the count, the output and the mode untouched. Any accepted write clears `load_err`.
- R4: In mode 0, a load drives `out` low. Each tick with the gate high decrements the count, and the tick that reaches 0 drives `out` high, where it stays until the next load.
- R5: In mode 0, a tick with the gate low leaves the count unchanged.
- R6: The gate is sampled only on ticks (`cnt_en`=1 and no write). A gate pulse that falls between two ticks is never seen.
- R7: In mode 1, the count waits for a gate rising edge. That tick loads N and drives `out` low. `out` returns high on the N-th following tick, when the count reaches 0, so the low pulse lasts N ticks.
- R8: In mode 1, a rising edge before terminal count reloads N and restarts the low pulse.
- R9: In mode 2 with the gate high, `out` is high for N-1 ticks and low for one tick, when the count is 1. The count then reloads N, giving a period of N ticks.
- R10: In mode 3, the count steps by 2 from the even load. With an odd N, `out` is high for (N+1)/2 ticks and low for (N-1)/2 ticks; with an even N, each phase lasts N/2 ticks.
- R11: In modes 2 and 3, a tick with the gate low forces `out` high and holds the count. A gate rising edge restarts from the beginning of the high phase with N reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter clock enable (one tick per high cycle) |
| gate | input | 1 | Gate level, sampled on ticks |
| wr_en | input | 1 | Host write strobe |
| wr_count | input | 16 | Initial count (0 means 65,536) |
| wr_mode | input | 2 | Mode select |
| out | output | 1 | Channel output |
| count_rd | output | 16 | Current count readback |
| load_err | output | 1 | Last write was rejected |

## Verification
Every result is registered, so a write or a tick at one clock edge shows on `out`, `count_rd` and `load_err` after that same edge and never later. The bench samples one time unit after each rising edge and compares all three outputs with a behavioural model that updates on the same edge. Directed windows then count high and low samples over whole periods, which confirms the duty figures of the one-shot, rate and square modes independently of the per-cycle model.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    M_LEVEL   = 2'd0,
    M_ONESHOT = 2'd1,
    M_RATE    = 2'd2,
    M_SQUARE  = 2'd3
  } pit_mode_e;
endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    gate_q <= 1'b0;
    else if (tick) gate_q <= gate;
  end

  assign gate_rise = tick & gate & ~gate_q;
endmodule

// File: rtl/pit_load_check.sv
module pit_load_check
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [1:0]       wr_mode,
  output logic             load_ok,
  output logic             load_rej,
  output logic [CNT_W:0]   load_val,
  output pit_mode_e        load_mode
);
  localparam logic [CNT_W:0] ONE = 1;

  function automatic logic [CNT_W:0] eff_count(input logic [CNT_W-1:0] v);
    if (v == '0) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, v};
  endfunction

  assign load_val  = eff_count(wr_count);
  assign load_mode = pit_mode_e'(wr_mode);
  assign load_rej  = wr_en && (load_mode == M_SQUARE) && (load_val == ONE);
  assign load_ok   = wr_en && !load_rej;
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic             gate_rise,
  input  logic             load_ok,
  input  logic [CNT_W:0]   load_val,
  input  pit_mode_e        load_mode,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W:0] ONE = 1;
  localparam logic [CNT_W:0] TWO = 2;

  pit_mode_e      mode_q;
  logic [CNT_W:0] reload_q, cnt_q;
  logic           run_q, hi_q, out_q;

  // named events for the checks
  logic tc_hit, sq_flip, gated_off;
  assign tc_hit    = (cnt_q == ONE);
  assign sq_flip   = (cnt_q == TWO);
  assign gated_off = tick && !gate && ((mode_q == M_RATE) || (mode_q == M_SQUARE));

  // even load for a square-wave phase
  function automatic logic [CNT_W:0] sq_load(input logic [CNT_W:0] n, input logic hi);
    if (!n[0]) return n;
    return hi ? n + ONE : n - ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_LEVEL;
      reload_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      hi_q     <= 1'b1;
      out_q    <= 1'b1;
    end else if (load_ok) begin
      mode_q   <= load_mode;
      reload_q <= load_val;
      run_q    <= (load_mode != M_ONESHOT);
      hi_q     <= 1'b1;
      out_q    <= (load_mode != M_LEVEL);
      cnt_q    <= (load_mode == M_SQUARE) ? sq_load(load_val, 1'b1) : load_val;
    end else if (tick) begin
      unique case (mode_q)
        M_LEVEL: begin
          if (run_q && gate) begin
            cnt_q <= cnt_q - ONE;
            if (tc_hit) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end
          end
        end
        M_ONESHOT: begin
          if (gate_rise) begin
            cnt_q <= reload_q;
            out_q <= 1'b0;
            run_q <= 1'b1;
          end else if (run_q) begin
            cnt_q <= cnt_q - ONE;
            if (tc_hit) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end
          end
        end
        M_RATE: begin
          if (gate_rise) begin
            cnt_q <= reload_q;
            out_q <= 1'b1;
          end else if (!gate) begin
            out_q <= 1'b1;
          end else if (tc_hit) begin
            cnt_q <= reload_q;
            out_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
            out_q <= !sq_flip;
          end
        end
        M_SQUARE: begin
          if (gate_rise) begin
            hi_q  <= 1'b1;
            out_q <= 1'b1;
            cnt_q <= sq_load(reload_q, 1'b1);
          end else if (!gate) begin
            out_q <= 1'b1;
          end else if (sq_flip) begin
            hi_q  <= ~hi_q;
            out_q <= ~hi_q;
            cnt_q <= sq_load(reload_q, ~hi_q);
          end else begin
            cnt_q <= cnt_q - TWO;
          end
        end
        default: ;
      endcase
    end
  end

  assign out_o   = out_q;
  assign count_o = cnt_q[CNT_W-1:0];

  // R4
  level_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && load_mode == M_LEVEL) |=> !out_q);
  // R4
  level_rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_q) && mode_q == M_LEVEL) |-> (cnt_q == '0));
  // R7
  oneshot_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONESHOT && gate_rise && !load_ok) |=> !out_q);
  // R9
  rate_low_at_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && !out_q) |-> (cnt_q == ONE));
  // R10
  square_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE) |-> !cnt_q[0]);
  // R11
  gate_off_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_off && !load_ok) |=> out_q);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [1:0]       wr_mode,
  output logic             out,
  output logic [CNT_W-1:0] count_rd,
  output logic             load_err
);
  logic           tick, gate_rise, load_ok, load_rej, err_q;
  logic [CNT_W:0] load_val;
  pit_mode_e      load_mode;

  // a write owns the cycle; its tick is dropped
  assign tick = cnt_en && !wr_en;

  pit_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .gate_rise(gate_rise)
  );

  pit_load_check #(.CNT_W(CNT_W)) u_chk (
    .wr_en(wr_en), .wr_count(wr_count), .wr_mode(wr_mode),
    .load_ok(load_ok), .load_rej(load_rej), .load_val(load_val), .load_mode(load_mode)
  );

  pit_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .gate_rise(gate_rise),
    .load_ok(load_ok), .load_val(load_val), .load_mode(load_mode),
    .out_o(out), .count_o(count_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (load_rej) err_q <= 1'b1;
    else if (load_ok)  err_q <= 1'b0;
  end
  assign load_err = err_q;

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_rej |=> ($stable(count_rd) && $stable(out) && load_err));
  // R3
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !load_err);
endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_count = '0;
  logic [1:0]  wr_mode = '0;
  logic        out;
  logic [15:0] count_rd;
  logic        load_err;

  pit_channel i_pit_channel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .wr_en(wr_en),
    .wr_count(wr_count), .wr_mode(wr_mode), .out(out), .count_rd(count_rd),
    .load_err(load_err)
  );

  always #5 clk = ~clk;

  int    errors = 0, checks = 0;
  int    div = 1, cyc_n = 0, wd = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference
  int m_mode, m_n, m_cnt, m_out, m_run, m_hi, m_gq, m_err;

  function automatic int half_load(int n, int hi);
    return hi ? 2 * ((n + 1) / 2) : 2 * (n / 2);
  endfunction

  always @(posedge clk) begin
    int n, rise;
    if (!rst_n) begin
      m_mode = 0; m_n = 0; m_cnt = 0; m_out = 1; m_run = 0; m_hi = 1; m_gq = 0; m_err = 0;
    end else if (wr_en) begin
      n = (wr_count == 0) ? 65536 : int'(wr_count);
      if (wr_mode == 3 && n == 1) m_err = 1;
      else begin
        m_err = 0; m_mode = int'(wr_mode); m_n = n; m_hi = 1;
        m_run = (m_mode != 1); m_out = (m_mode != 0);
        m_cnt = (m_mode == 3) ? half_load(n, 1) : n;
      end
    end else if (cnt_en) begin
      rise = (gate && !m_gq);
      m_gq = gate;
      case (m_mode)
        0: if (m_run && gate) begin
             m_cnt--; if (m_cnt == 0) begin m_out = 1; m_run = 0; end
           end
        1: if (rise) begin m_cnt = m_n; m_out = 0; m_run = 1; end
           else if (m_run) begin
             m_cnt--; if (m_cnt == 0) begin m_out = 1; m_run = 0; end
           end
        2: if (rise) begin m_cnt = m_n; m_out = 1; end
           else if (!gate) m_out = 1;
           else begin
             m_cnt--;
             if (m_cnt == 0) begin m_cnt = m_n; m_out = 1; end
             else m_out = (m_cnt != 1);
           end
        default: if (rise) begin m_hi = 1; m_out = 1; m_cnt = half_load(m_n, 1); end
           else if (!gate) m_out = 1;
           else begin
             m_cnt -= 2;
             if (m_cnt == 0) begin m_hi = !m_hi; m_out = m_hi; m_cnt = half_load(m_n, m_hi); end
           end
      endcase
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc_n);
    end
  endtask

  // one clock: sample after the edge, compare, then drive the next enable
  task automatic cyc();
    @(posedge clk);
    #1;
    cyc_n++;
    if (rst_n) begin
      check(tag, "out", int'(out), m_out);
      check(tag, "count_rd", int'(count_rd), m_cnt % 65536);
      check(tag, "load_err", int'(load_err), m_err);
    end
    cnt_en = (div != 0) && ((cyc_n % (div == 0 ? 1 : div)) == 0);
  endtask

  task automatic wr(input int mode, input int val);
    wr_en = 1'b1; wr_mode = 2'(mode); wr_count = 16'(val);
    cyc();
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", wd, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int cnt_hi, lows, held;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    check("R1", "out after reset", int'(out), 1);
    check("R1", "count after reset", int'(count_rd), 0);
    check("R1", "err after reset", int'(load_err), 0);

    // R4: level mode, gate high
    tag = "R4"; gate = 1'b1; div = 1;
    wr(0, 5);
    check("R4", "out low after load", int'(out), 0);
    repeat (8) cyc();
    check("R4", "out high after terminal", int'(out), 1);

    // R5: gate low holds
    tag = "R5";
    wr(0, 6);
    repeat (2) cyc();
    gate = 1'b0; cyc();
    held = int'(count_rd);
    repeat (4) cyc();
    check("R5", "count held with gate low", int'(count_rd), held);
    gate = 1'b1; repeat (8) cyc();

    // R2: value 0 means 65536; sparse ticks; write beats tick
    tag = "R2"; gate = 1'b0;
    wr(0, 0);
    check("R2", "zero load reads 0", int'(count_rd), 0);
    gate = 1'b1; div = 3; repeat (6) cyc();
    check("R2", "count after two ticks from 65536", int'(count_rd), 65534);
    div = 1; cyc();
    wr(0, 9);
    check("R2", "write wins over tick", int'(count_rd), 9);

    // R3: rejected square load
    tag = "R3";
    wr(3, 1);
    check("R3", "err set", int'(load_err), 1);
    check("R3", "count untouched", int'(count_rd), 9);
    cyc();

    // R10: square N=5, 20 samples hold 12 high
    tag = "R10";
    wr(3, 5);
    check("R3", "err cleared", int'(load_err), 0);
    cnt_hi = int'(out);
    for (int i = 0; i < 19; i++) begin cyc(); cnt_hi += int'(out); end
    check("R10", "high samples N=5", cnt_hi, 12);
    wr(3, 4);
    cnt_hi = int'(out);
    for (int i = 0; i < 19; i++) begin cyc(); cnt_hi += int'(out); end
    check("R10", "high samples N=4", cnt_hi, 10);
    div = 3; repeat (30) cyc(); div = 1;

    // R9: rate N=4, one low per period
    tag = "R9";
    wr(2, 4);
    lows = int'(!out);
    for (int i = 0; i < 19; i++) begin cyc(); lows += int'(!out); end
    check("R9", "low samples N=4", lows, 5);

    // R11: gate off in rate mode
    tag = "R11";
    repeat (2) cyc();
    gate = 1'b0; cyc();
    check("R11", "out high with gate low", int'(out), 1);
    held = int'(count_rd);
    repeat (3) cyc();
    check("R11", "count held with gate low", int'(count_rd), held);
    gate = 1'b1; cyc();
    check("R11", "restart loads N", int'(count_rd), 4);
    repeat (6) cyc();
    wr(3, 7); repeat (5) cyc();
    gate = 1'b0; repeat (3) cyc();
    gate = 1'b1; cyc();
    check("R11", "square restart count", int'(count_rd), 8);
    repeat (10) cyc();

    // R7: one-shot N=3
    tag = "R7"; gate = 1'b0;
    wr(1, 3);
    repeat (2) cyc();
    gate = 1'b1; lows = 0;
    for (int i = 0; i < 10; i++) begin cyc(); lows += int'(!out); end
    check("R7", "one-shot low length", lows, 3);

    // R8: retrigger mid-pulse
    tag = "R8";
    gate = 1'b0; repeat (2) cyc();
    lows = 0;
    gate = 1'b1; cyc(); lows += int'(!out);
    cyc(); lows += int'(!out);
    gate = 1'b0; cyc(); lows += int'(!out);
    gate = 1'b1;
    for (int i = 0; i < 8; i++) begin cyc(); lows += int'(!out); end
    check("R8", "retriggered low length", lows, 6);

    // R6: gate pulse between ticks is invisible
    tag = "R6";
    gate = 1'b0; repeat (2) cyc();
    div = 0; repeat (2) cyc();
    gate = 1'b1; repeat (2) cyc();
    gate = 1'b0; cyc();
    div = 1; lows = 0;
    for (int i = 0; i < 6; i++) begin cyc(); lows += int'(!out); end
    check("R6", "no trigger from unsampled pulse", lows, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule